// File: doc/BRIEF.md
# Dual Tick Timer: One-Shot and Periodic

This block holds two tick-driven 32-bit timers behind one simple register slave. One timer fires once and then disarms itself. The other fires again and again at a fixed interval. Each timer has a load register and a remaining-ticks register. The load register reads back the value last programmed. The remaining-ticks register is read-only and reports how far away the next expiry is. Each timer drives its own interrupt pulse output.

Both counters advance only on cycles where the shared tick enable input is high. That input usually comes from a prescaler outside the block. Software starts a timer by writing a nonzero interval and stops it by writing zero. All four registers carry big-endian 32-bit values and accept only full-word accesses. Any other access width raises an error flag for that cycle and leaves the block unchanged.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset, all four registers read 0 and both interrupt outputs are low.
- R2: Byte lane k of the data buses (bits 8k+7..8k) carries register byte offset+k. The value is big-endian, so lane 0 holds the most significant byte. A data word of 32'h03000000 therefore means 3.
- R3: The register offsets on the 6-bit address are:
  - 0x20: one-shot load
  - 0x24: one-shot remaining
  - 0x28: periodic load
  - 0x2C: periodic remaining
  
  Reads at any other offset return 0 with no error.
- R4: An access to any of the four offsets with a byte count other than 4 raises bus_err in that cycle. Such a write changes nothing, and such a read returns 0.
- R5: A nonzero write of V to a load register sets both the load and the remaining value to V, and cancels any expiry in progress. The timer then expires on the V-th tick after the write.
- R6: Writing 0 to a load register stops the timer. Its load and remaining values then read 0, and no interrupt follows.
- R7: While a timer is active, its remaining value drops by one at each clock edge where tick_en is high. It holds when tick_en is low.
- R8: On one-shot expiry, oneshot_irq is high for exactly the one cycle after the edge of the V-th tick. The one-shot load and remaining values both become 0.
- R9: The periodic timer pulses periodic_irq once every V ticks. On each expiry its remaining value reloads to V, and its load value stays at V.
- R10: A load write in the same cycle as a tick takes precedence. That tick neither decrements the timer nor produces an expiry.
- R11: Writes to the remaining-ticks offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances both timers by one tick |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_bytes | input | 3 | Number of bytes in the access |
| bus_wdata | input | 32 | Write data, byte lane k at offset+k |
| bus_rdata | output | 32 | Read data, same lane order, combinational |
| bus_err | output | 1 | Wrong-width access to a timer register |
| oneshot_irq | output | 1 | One-cycle pulse on one-shot expiry |
| periodic_irq | output | 1 | One-cycle pulse on each periodic expiry |

## Verification
The hardest case to reach is a load write that lands in exactly the cycle where a tick would have expired the timer. To get there, the stimulus counts the timer down to a remaining value of 1. It then issues the rewrite with tick_en held high in the same cycle, and checks both that no pulse appears and that the new interval counts out in full. Intervals 1 to 5 are swept against tick spacings of one, two and three cycles on both timers. This sweep covers back-to-back periodic pulses at V=1 and the hold behaviour between sparse ticks.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;
  localparam int ADDR_W = 6;

  localparam int OFF_OS_LOAD = 'h20;
  localparam int OFF_OS_REM  = 'h24;
  localparam int OFF_PE_LOAD = 'h28;
  localparam int OFF_PE_REM  = 'h2C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OS_LOAD,
    SEL_OS_REM,
    SEL_PE_LOAD,
    SEL_PE_REM
  } sel_e;

  // Reverse byte lanes: lane 0 <-> most significant byte of the value.
  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    for (int i = 0; i < NBYTES; i++) begin
      y[8*i +: 8] = x[8*(NBYTES-1-i) +: 8];
    end
    return y;
  endfunction
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tt_decode.sv
module tt_decode
  import tt_pkg::*;
#(
  parameter int ADDR_W = tt_pkg::ADDR_W,
  parameter int NBYTES = tt_pkg::NBYTES
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        nbytes,
  output logic              wr_os,
  output logic              wr_pe,
  output sel_e              rd_sel,
  output logic              err
);
  sel_e sel;
  logic size_ok;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_OS_LOAD)) sel = SEL_OS_LOAD;
    else if (addr == ADDR_W'(OFF_OS_REM))  sel = SEL_OS_REM;
    else if (addr == ADDR_W'(OFF_PE_LOAD)) sel = SEL_PE_LOAD;
    else if (addr == ADDR_W'(OFF_PE_REM))  sel = SEL_PE_REM;
  end

  assign size_ok = (nbytes == 3'(NBYTES));
  assign err     = req && (sel != SEL_NONE) && !size_ok;
  assign wr_os   = req && we && size_ok && (sel == SEL_OS_LOAD);
  assign wr_pe   = req && we && size_ok && (sel == SEL_PE_LOAD);
  assign rd_sel  = (req && !we && size_ok) ? sel : SEL_NONE;
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W    = 32,
  parameter bit PERIODIC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] rem_q,
  output logic             expire_q
);
  logic [CNT_W-1:0] load_d, rem_d;
  logic             expire_d;
  logic             active, last_tick;

  assign active    = (load_q != '0);
  assign last_tick = (rem_q == CNT_W'(1));

  always_comb begin
    load_d   = load_q;
    rem_d    = rem_q;
    expire_d = 1'b0;
    if (wr_en) begin
      load_d = wr_val;
      rem_d  = wr_val;
    end else if (tick && active) begin
      if (last_tick) begin
        expire_d = 1'b1;
        if (PERIODIC) begin
          rem_d = load_q;
        end else begin
          load_d = '0;
          rem_d  = '0;
        end
      end else begin
        rem_d = rem_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '0;
      rem_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      load_q   <= load_d;
      rem_q    <= rem_d;
      expire_q <= expire_d;
    end
  end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tt_pkg::*;
#(
  parameter int ADDR_W = tt_pkg::ADDR_W,
  parameter int DATA_W = tt_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_bytes,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              oneshot_irq,
  output logic              periodic_irq
);
  localparam int NB = DATA_W / 8;

  logic              rst_int_n;
  logic              wr_os, wr_pe;
  sel_e              rd_sel;
  logic [DATA_W-1:0] wval;
  logic [DATA_W-1:0] os_load, os_rem, pe_load, pe_rem;
  logic [DATA_W-1:0] rval;

  tt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tt_decode #(.ADDR_W(ADDR_W), .NBYTES(NB)) u_dec (
    .req    (bus_req),
    .we     (bus_we),
    .addr   (bus_addr),
    .nbytes (bus_bytes),
    .wr_os  (wr_os),
    .wr_pe  (wr_pe),
    .rd_sel (rd_sel),
    .err    (bus_err)
  );

  // Big-endian value from byte lanes.
  for (genvar b = 0; b < NB; b++) begin : g_wswap
    assign wval[8*b +: 8] = bus_wdata[8*(NB-1-b) +: 8];
  end

  tt_counter #(.CNT_W(DATA_W), .PERIODIC(1'b0)) u_os (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick_en),
    .wr_en    (wr_os),
    .wr_val   (wval),
    .load_q   (os_load),
    .rem_q    (os_rem),
    .expire_q (oneshot_irq)
  );

  tt_counter #(.CNT_W(DATA_W), .PERIODIC(1'b1)) u_pe (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick_en),
    .wr_en    (wr_pe),
    .wr_val   (wval),
    .load_q   (pe_load),
    .rem_q    (pe_rem),
    .expire_q (periodic_irq)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_OS_LOAD: rval = os_load;
      SEL_OS_REM:  rval = os_rem;
      SEL_PE_LOAD: rval = pe_load;
      SEL_PE_REM:  rval = pe_rem;
      default:     rval = '0;
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_rswap
    assign bus_rdata[8*b +: 8] = rval[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/tick_timer_pair_chk.sv
module tick_timer_pair_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_bytes,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_err,
  input logic              oneshot_irq,
  input logic              periodic_irq,
  input logic [DATA_W-1:0] os_load,
  input logic [DATA_W-1:0] os_rem,
  input logic [DATA_W-1:0] pe_load,
  input logic [DATA_W-1:0] pe_rem
);
  logic hit, full, os_wr, pe_wr, bad;

  assign hit   = (bus_addr == ADDR_W'('h20)) || (bus_addr == ADDR_W'('h24)) ||
                 (bus_addr == ADDR_W'('h28)) || (bus_addr == ADDR_W'('h2C));
  assign full  = (bus_bytes == 3'd4);
  assign os_wr = bus_req && bus_we && full && (bus_addr == ADDR_W'('h20));
  assign pe_wr = bus_req && bus_we && full && (bus_addr == ADDR_W'('h28));
  assign bad   = bus_req && hit && !full;

  a_r4_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err == bad);

  a_r4_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable(pe_load));

  a_r6_zero_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (os_wr && bus_wdata == '0) |=> (os_load == '0 && os_rem == '0));

  a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !os_wr) |=> ($stable(os_rem) && !oneshot_irq));

  a_r8_oneshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_irq |-> (os_load == '0 && os_rem == '0));

  a_r8_oneshot_single: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_irq |=> !oneshot_irq);

  a_r9_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_irq |-> (pe_rem == pe_load && pe_load != '0));

  a_r10_os_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    os_wr |=> !oneshot_irq);

  a_r10_pe_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pe_wr |=> !periodic_irq);
endmodule

bind tick_timer_pair tick_timer_pair_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_bytes    (bus_bytes),
  .bus_wdata    (bus_wdata),
  .bus_err      (bus_err),
  .oneshot_irq  (oneshot_irq),
  .periodic_irq (periodic_irq),
  .os_load      (os_load),
  .os_rem       (os_rem),
  .pe_load      (pe_load),
  .pe_rem       (pe_rem)
);

// File: tb/tick_timer_pair_tb.sv
module tick_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_req, bus_we;
  logic [5:0]  bus_addr;
  logic [2:0]  bus_bytes;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err, oneshot_irq, periodic_irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  tick_timer_pair u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_bytes(bus_bytes), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .oneshot_irq(oneshot_irq), .periodic_irq(periodic_irq)
  );

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle();
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_bytes = 3'd4; bus_wdata = '0; tick_en = 0;
  endtask

  // One clock; inputs change and outputs are sampled 1 ns after the edge.
  task automatic cyc(input logic t);
    tick_en = t;
    @(posedge clk); #1;
    tick_en = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [2:0] nb,
                    input logic t, output logic e);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_bytes = nb; bus_wdata = d; tick_en = t;
    #1 e = bus_err;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic rd(input logic [5:0] a, input logic [2:0] nb,
                    output logic [31:0] d, output logic e);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_bytes = nb;
    #1 d = bus_rdata; e = bus_err;
    bus_req = 0;
  endtask

  task automatic chk_reg(input string rq, input logic [5:0] a, input logic [31:0] val);
    logic [31:0] d; logic e;
    rd(a, 3'd4, d, e);
    check(rq, d, sw(val));
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic e;
    logic [31:0] d;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) cyc(0);

    // R1 reset state
    chk_reg("R1", 6'h20, 0); chk_reg("R1", 6'h24, 0);
    chk_reg("R1", 6'h28, 0); chk_reg("R1", 6'h2C, 0);
    check("R1", {oneshot_irq, periodic_irq}, 0);

    // R3 unmapped offsets read 0, no error
    rd(6'h00, 3'd4, d, e); check("R3", {d, e} == 0, 1);
    rd(6'h30, 3'd4, d, e); check("R3", {d, e} == 0, 1);

    // R4 wrong width
    wr(6'h28, sw(7), 3'd2, 0, e); check("R4", e, 1);
    chk_reg("R4", 6'h28, 0);
    rd(6'h24, 3'd1, d, e); check("R4", e, 1); check("R4", d, 0);

    // R11 write to remaining offsets ignored
    wr(6'h24, sw(9), 3'd4, 0, e); check("R11", e, 0);
    wr(6'h2C, sw(9), 3'd4, 0, e);
    chk_reg("R11", 6'h24, 0); chk_reg("R11", 6'h2C, 0);
    for (int i = 0; i < 12; i++) begin
      cyc(1); check("R11", {oneshot_irq, periodic_irq}, 0);
    end

    // R2 byte order: lane 3 carries the least significant byte, value 3
    wr(6'h20, 32'h0300_0000, 3'd4, 0, e);
    rd(6'h20, 3'd4, d, e); check("R2", d, 32'h0300_0000);
    cyc(1); cyc(1); check("R2", oneshot_irq, 0);
    cyc(1); check("R2", oneshot_irq, 1);
    cyc(0); check("R2", oneshot_irq, 0);

    // R6 zero write cancels
    wr(6'h20, sw(5), 3'd4, 0, e);
    cyc(1); cyc(1);
    wr(6'h20, 0, 3'd4, 0, e);
    chk_reg("R6", 6'h20, 0); chk_reg("R6", 6'h24, 0);
    for (int i = 0; i < 10; i++) begin
      cyc(1); check("R6", oneshot_irq, 0);
    end
    wr(6'h28, sw(2), 3'd4, 0, e);
    cyc(1);
    wr(6'h28, 0, 3'd4, 0, e);
    for (int i = 0; i < 6; i++) begin
      cyc(1); check("R6", periodic_irq, 0);
    end
    chk_reg("R6", 6'h2C, 0);

    // R5 rewrite restarts
    wr(6'h20, sw(5), 3'd4, 0, e);
    cyc(1); cyc(1); cyc(1);
    wr(6'h20, sw(2), 3'd4, 0, e);
    chk_reg("R5", 6'h24, 2);
    cyc(1); check("R5", oneshot_irq, 0);
    cyc(1); check("R5", oneshot_irq, 1);

    // R10 write coinciding with the expiry tick
    wr(6'h20, sw(2), 3'd4, 0, e);
    cyc(1); chk_reg("R10", 6'h24, 1);
    wr(6'h20, sw(4), 3'd4, 1, e);
    check("R10", oneshot_irq, 0);
    chk_reg("R10", 6'h24, 4);
    for (int i = 1; i <= 4; i++) begin
      cyc(1); check("R10", oneshot_irq, (i == 4));
    end
    wr(6'h28, sw(1), 3'd4, 0, e);
    wr(6'h28, sw(3), 3'd4, 1, e);
    check("R10", periodic_irq, 0);
    chk_reg("R10", 6'h2C, 3);
    wr(6'h28, 0, 3'd4, 0, e);

    // R7/R8/R9 sweep: interval V, tick every gap+1 cycles, both timers
    for (int pe = 0; pe < 2; pe++) begin
      for (int v = 1; v <= 5; v++) begin
        for (int gap = 0; gap < 3; gap++) begin
          int n;
          int steps;
          logic [5:0] la, ra;
          la = pe ? 6'h28 : 6'h20;
          ra = pe ? 6'h2C : 6'h24;
          wr(la, sw(v), 3'd4, 0, e);
          n = 0;
          steps = (pe ? 3 * v : v) * (gap + 1) + 2;
          for (int s = 0; s < steps; s++) begin
            logic t;
            logic exp_irq;
            t = ((s % (gap + 1)) == gap);
            cyc(t);
            if (t) n++;
            if (pe) begin
              exp_irq = t && (n % v == 0);
              check("R9", periodic_irq, exp_irq);
              check("R9", oneshot_irq, 0);
              chk_reg("R9", la, v);
              chk_reg("R7", ra, v - (n % v));
            end else begin
              exp_irq = t && (n == v);
              check("R8", oneshot_irq, exp_irq);
              check("R8", periodic_irq, 0);
              chk_reg("R8", la, (n < v) ? v : 0);
              chk_reg("R7", ra, (n < v) ? v - n : 0);
            end
          end
          wr(la, 0, 3'd4, 0, e);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule